// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recently used page translations. Each entry holds a virtual page number, the physical frame number it maps to, and a valid flag. A lookup presents a full virtual address. The virtual page number is compared against every entry in the same cycle. When a valid entry matches, the block returns the physical address as combinational logic: the stored frame number joined to the unchanged 12-bit page offset. When no valid entry matches, it raises a miss flag and returns no translation. An outside agent, such as a miss handler running in software or a hardware page walker, then finds the mapping and installs it.

Installation goes through a write port. The port also accepts entries before any miss, so translations can be preloaded. Each write picks its target slot in one of three selection modes, listed in priority order:
- **Reuse**: a valid entry already holds the same virtual page.
- **Free**: the lowest-numbered invalid slot.
- **Rotate**: the slot named by a round-robin pointer.

The mode is chosen again for every write and does not persist from one write to the next. The round-robin pointer advances once on every accepted write. A flush input drops every entry in a single cycle.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is invalid. Every lookup misses, including a lookup of virtual page 0, and the round-robin pointer is 0.
- R2: When `lk_req` is 1 and a valid entry holds the requested virtual page, `lk_hit` is 1 and `lk_miss` is 0 in the same cycle, with no clock edge in between.
- R3: On a hit, `lk_paddr` is the entry's 20-bit frame number in bits 31:12, and `lk_vaddr[11:0]` passed through unchanged in bits 11:0.
- R4: When `lk_req` is 1 and no valid entry matches, `lk_miss` is 1, `lk_hit` is 0 and `lk_paddr` is 0. When `lk_req` is 0, `lk_hit` and `lk_miss` are both 0.
- R5: A write with `wr_en` at 1 takes effect at the next rising clock edge. A lookup made in the same cycle as the write sees the contents from before the write.
- R6: Writing a virtual page that a valid entry already holds overwrites that entry's frame number and does not create a second entry.
- R7: A write that matches no valid entry, made while an invalid slot exists, fills the lowest-numbered invalid slot and evicts nothing.
- R8: When all slots are valid and the written page matches none of them, the write replaces the slot named by the round-robin pointer. The pointer advances by one, wrapping from 15 to 0, on every accepted write in any selection mode. It advances only on accepted writes.
- R9: A flush at 1 clears every valid flag at the next edge. A write in the same cycle as a flush is ignored and does not advance the pointer.
- R10: An entry whose valid flag is clear never produces a hit, even if its stored page number equals the requested one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | A valid entry matched |
| lk_miss | output | 1 | Request with no valid match |
| lk_paddr | output | 32 | Translated address, 0 on a miss |
| wr_en | input | 1 | Install an entry |
| wr_vpn | input | 20 | Virtual page number to install |
| wr_pfn | input | 20 | Frame number to install |
| flush | input | 1 | Invalidate all entries |

## Verification
A valid flag in the wrong state shows up at the next lookup of that page. A flag that is set when it should be clear turns a miss into a hit. A flag that is clear when it should be set turns a hit into a miss. A wrong reuse decision leaves two entries for one page. This stays hidden until the buffer fills, and then shows up as an earlier eviction, which is a miss on a page that should still hit. A pointer that is off by one, or that advances on an ignored write, is seen only once every slot is valid. At that point the wrong page misses on the first lookup after the next replacement. The bench therefore checks the state of every slot after each replacement.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W    = 32;
    localparam int PA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int ENTRIES = 16;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PFN_W   = PA_W - OFF_W;
    localparam int IDX_W   = $clog2(ENTRIES);

    // slot selection modes for a write
    typedef enum logic [1:0] {
        SEL_REUSE  = 2'd0,
        SEL_FREE   = 2'd1,
        SEL_ROTATE = 2'd2
    } sel_mode_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int N     = xlat_pkg::ENTRIES,
    parameter int KEY_W = xlat_pkg::VPN_W,
    localparam int IW   = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][KEY_W-1:0] keys,
    input  logic [KEY_W-1:0]        probe,
    output logic [N-1:0]            hit_vec,
    output logic                    hit_any,
    output logic [IW-1:0]           hit_idx
);
    // one comparator per slot, all active together
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (keys[g] == probe);
    end

    assign hit_any = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IW'(i);
        end
    end

    // R6
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
#(
    parameter int N   = ENTRIES,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  valid,
    input  logic          same_any,
    input  logic [IW-1:0] same_idx,
    input  logic          wr_accept,
    output logic [IW-1:0] victim,
    output sel_mode_e     mode
);
    logic [IW-1:0] rr_q;
    logic          free_any;
    logic [IW-1:0] free_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    always_comb begin
        if (same_any)      mode = SEL_REUSE;
        else if (free_any) mode = SEL_FREE;
        else               mode = SEL_ROTATE;
    end

    always_comb begin
        unique case (mode)
            SEL_REUSE:  victim = same_idx;
            SEL_FREE:   victim = free_idx;
            SEL_ROTATE: victim = rr_q;
            default:    victim = rr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         rr_q <= '0;
        else if (wr_accept) rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end

    // R7
    free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SEL_FREE) |-> !valid[victim]);
    // R8
    rotate_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SEL_ROTATE) |-> (&valid));
    // R6
    reuse_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SEL_REUSE) |-> valid[victim]);
    // R8
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_accept |=> $stable(rr_q));
endmodule

// File: rtl/xlat_store.sv
module xlat_store #(
    parameter int N     = xlat_pkg::ENTRIES,
    parameter int VPN_W = xlat_pkg::VPN_W,
    parameter int PFN_W = xlat_pkg::PFN_W,
    localparam int IW   = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    wr_accept,
    input  logic [IW-1:0]           slot,
    input  logic [VPN_W-1:0]        vpn_in,
    input  logic [PFN_W-1:0]        pfn_in,
    output logic [N-1:0]            valid_q,
    output logic [N-1:0][VPN_W-1:0] vpn_q,
    output logic [N-1:0][PFN_W-1:0] pfn_q
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        logic take;
        assign take = wr_accept && (slot == IW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                vpn_q[g]   <= '0;
                pfn_q[g]   <= '0;
            end else if (flush) begin
                valid_q[g] <= 1'b0;
            end else if (take) begin
                valid_q[g] <= 1'b1;
                vpn_q[g]   <= vpn_in;
                pfn_q[g]   <= pfn_in;
            end
        end
    end

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
    // R5
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> valid_q[$past(slot)]);
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic             flush
);
    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
    logic [ENTRIES-1:0]            lk_vec, wr_vec;
    logic                          lk_any, wr_any;
    logic [IDX_W-1:0]              lk_idx, wr_idx, victim;
    sel_mode_e                     mode;
    logic                          wr_accept;

    assign wr_accept = wr_en && !flush;

    xlat_match #(.N(ENTRIES), .KEY_W(VPN_W)) u_lk_cam (
        .clk(clk), .rst_n(rst_n), .valid(valid_q), .keys(vpn_q),
        .probe(lk_vaddr[VA_W-1:OFF_W]),
        .hit_vec(lk_vec), .hit_any(lk_any), .hit_idx(lk_idx));

    xlat_match #(.N(ENTRIES), .KEY_W(VPN_W)) u_wr_cam (
        .clk(clk), .rst_n(rst_n), .valid(valid_q), .keys(vpn_q),
        .probe(wr_vpn),
        .hit_vec(wr_vec), .hit_any(wr_any), .hit_idx(wr_idx));

    xlat_victim #(.N(ENTRIES)) u_pick (
        .clk(clk), .rst_n(rst_n), .valid(valid_q),
        .same_any(wr_any), .same_idx(wr_idx), .wr_accept(wr_accept),
        .victim(victim), .mode(mode));

    xlat_store #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_accept(wr_accept),
        .slot(victim), .vpn_in(wr_vpn), .pfn_in(wr_pfn),
        .valid_q(valid_q), .vpn_q(vpn_q), .pfn_q(pfn_q));

    always_comb begin
        lk_hit   = lk_req && lk_any;
        lk_miss  = lk_req && !lk_any;
        lk_paddr = lk_hit ? {pfn_q[lk_idx], lk_vaddr[OFF_W-1:0]} : '0;
    end

    // R2
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> (lk_hit ^ lk_miss));
    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_paddr == '0));
endmodule

// File: tb/sim_xlat_buffer.sv
module sim_xlat_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss;
    logic [31:0] lk_paddr;
    logic        wr_en = 1'b0;
    logic [19:0] wr_vpn = '0;
    logic [19:0] wr_pfn = '0;
    logic        flush = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    xlat_buffer u0 (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_pfn(wr_pfn), .flush(flush));

    // {vaddr, expect_hit, expect_paddr} after preloading four pages
    localparam logic [64:0] VEC [8] = '{
        {32'h0001_0000, 1'b1, 32'h00A0_0000},
        {32'h0001_0FFF, 1'b1, 32'h00A0_0FFF},
        {32'h0002_07A5, 1'b1, 32'h00B0_07A5},
        {32'h1234_5678, 1'b1, 32'hFEDC_B678},
        {32'hFFFF_F001, 1'b1, 32'h0000_1001},
        {32'h0001_1000, 1'b0, 32'h0000_0000},
        {32'h0000_0123, 1'b0, 32'h0000_0000},
        {32'h1234_4678, 1'b0, 32'h0000_0000}
    };

    task automatic look(input logic [31:0] va, input bit eh, input logic [31:0] ep,
                        input string req);
        @(negedge clk);
        lk_req = 1'b1;
        lk_vaddr = va;
        #1;
        checks++;
        if (lk_hit !== eh || lk_miss !== !eh || lk_paddr !== ep) begin
            errors++;
            $display("FAIL %s va=%h: hit=%b miss=%b pa=%h expected hit=%b miss=%b pa=%h",
                     req, va, lk_hit, lk_miss, lk_paddr, eh, !eh, ep);
        end
    endtask

    task automatic put(input logic [19:0] v, input logic [19:0] p);
        @(negedge clk);
        lk_req = 1'b0;
        wr_en = 1'b1;
        wr_vpn = v;
        wr_pfn = p;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset: everything misses, page 0 included
        look(32'h0000_0000, 1'b0, 32'h0, "R1");
        look(32'h0001_0000, 1'b0, 32'h0, "R1");

        put(20'h00010, 20'h00A00);
        put(20'h00020, 20'h00B00);
        put(20'h12345, 20'hFEDCB);
        put(20'hFFFFF, 20'h00001);
        // R2 R3 R4 R10 table walk
        for (int i = 0; i < 8; i++)
            look(VEC[i][64:33], VEC[i][32], VEC[i][31:0], "R2/R3/R4/R10");

        // R4 idle request gives neither flag
        @(negedge clk);
        lk_req = 1'b0;
        lk_vaddr = 32'h0001_0000;
        #1;
        checks++;
        if (lk_hit !== 1'b0 || lk_miss !== 1'b0) begin
            errors++;
            $display("FAIL R4 idle: hit=%b miss=%b expected 0 0", lk_hit, lk_miss);
        end

        // R6 reinstall same page: overwrite in place
        put(20'h00020, 20'h00C00);
        look(32'h0002_0010, 1'b1, 32'h00C0_0010, "R6");
        // R7 twelve more fill free slots 4..15, nothing evicted
        for (int i = 0; i < 12; i++) put(20'h40000 + 20'(i), 20'h80000 + 20'(i));
        look(32'h0001_0123, 1'b1, 32'h00A0_0123, "R6/R7");
        look(32'h0002_0123, 1'b1, 32'h00C0_0123, "R6/R7");
        look(32'h1234_5123, 1'b1, 32'hFEDC_B123, "R7");
        look(32'hFFFF_F123, 1'b1, 32'h0000_1123, "R7");
        for (int i = 0; i < 12; i++)
            look({20'h40000 + 20'(i), 12'h0AB}, 1'b1, {20'h80000 + 20'(i), 12'h0AB}, "R7");

        // R8 17 writes so far: pointer at 1
        put(20'h55555, 20'h0E0E0);
        look(32'h0002_0000, 1'b0, 32'h0, "R8");
        look(32'h5555_5321, 1'b1, 32'h0E0E_0321, "R8");
        look(32'h0001_0000, 1'b1, 32'h00A0_0000, "R8");
        put(20'h66666, 20'h0F0F0);
        look(32'h1234_5000, 1'b0, 32'h0, "R8");
        look(32'h6666_6000, 1'b1, 32'h0F0F_0000, "R8");
        look(32'hFFFF_F000, 1'b1, 32'h0000_1000, "R8");

        // R5 lookup in the write cycle sees old contents; slot 3 replaced
        @(negedge clk);
        wr_en = 1'b1;
        wr_vpn = 20'h77777;
        wr_pfn = 20'h07777;
        lk_req = 1'b1;
        lk_vaddr = 32'h7777_7000;
        #1;
        checks++;
        if (lk_hit !== 1'b0 || lk_miss !== 1'b1) begin
            errors++;
            $display("FAIL R5 same-cycle: hit=%b miss=%b expected 0 1", lk_hit, lk_miss);
        end
        @(negedge clk);
        wr_en = 1'b0;
        look(32'h7777_7444, 1'b1, 32'h0777_7444, "R5");
        look(32'hFFFF_F000, 1'b0, 32'h0, "R5/R8");

        // R9 flush then flush with simultaneous write
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        look(32'h0001_0000, 1'b0, 32'h0, "R9/R10");
        look(32'h5555_5000, 1'b0, 32'h0, "R9/R10");
        @(negedge clk);
        flush = 1'b1;
        wr_en = 1'b1;
        wr_vpn = 20'h01234;
        wr_pfn = 20'h00999;
        @(negedge clk);
        flush = 1'b0;
        wr_en = 1'b0;
        look(32'h0123_4000, 1'b0, 32'h0, "R9");

        // R8 R9: 20 accepted writes, pointer 4; 16 fills then one rotate
        for (int i = 0; i < 16; i++) put(20'h30000 + 20'(i), 20'h31000 + 20'(i));
        put(20'h3FFFF, 20'h00042);
        look(32'h3000_4000, 1'b0, 32'h0, "R8/R9");
        look(32'h3000_3000, 1'b1, 32'h3100_3000, "R8");
        look(32'h3000_5000, 1'b1, 32'h3100_5000, "R8");
        look(32'h3FFF_F000, 1'b1, 32'h0004_2000, "R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule